// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Clock with Alarm

This core keeps a 32-bit count of seconds from a slow oscillator. The oscillator reaches the core as a one-cycle enable pulse `osc_en` in the system clock domain. A tick counter counts these pulses. Once it has counted the number held in the calibration register, it marks a second boundary. An optional fractional correction adds one extra pulse to a chosen number of seconds in every sixteen. Software reaches the core over a plain 32-bit register bus. Writes take effect on the clock edge that samples `bus_wr`. Reads are captured into `bus_rdata` on the edge that samples `bus_rd`.

Software sets the time by writing a set-time register. The new value does not show in the current-time register at once: it is loaded at the next second boundary. Writing the calibration register restarts the tick counter, so the next boundary comes exactly one calibrated period after that write. Each boundary raises a seconds status bit. A boundary that makes the time equal to the alarm value raises an alarm status bit. Both status bits are write-one-to-clear. Each source can be enabled or disabled one at a time, and the enabled sources drive the interrupt line.

Two small state machines sit inside the core:
- The tick unit has the states COUNT and PAD. COUNT goes to PAD when the counter reaches the programmed count and the current second is owed a correction pulse. PAD goes back to COUNT on the next pulse, and that pulse is the boundary. COUNT stays in COUNT when a boundary occurs with no correction. A calibration write forces COUNT.
- The time unit has the states RUN and ARMED. RUN goes to ARMED on a set-time write. ARMED goes back to RUN at a boundary, which loads the stored value. In RUN, each boundary adds one to the time.

Top module: `secs_rtc_core`

## Requirements
- R1: After reset, the calibration readback is 0x198233 and the current time is 0. The interrupt status and the enable state read 0, and `irq` is low.
- R2: The word address is the byte offset divided by four. The registers are:
  - 0 set-time write and 1 set-time readback.
  - 2 calibration write and 3 calibration readback; only bits 20:0 are kept.
  - 4 current time and 5 current tick.
  - 6 alarm, which reads back all 32 bits.
  - 8 status, 9 enable state, 10 enable and 11 disable.
  - 16 control, which stores and returns only bits 31 and 24.
- R3: With correction off, each second lasts N+1 `osc_en` pulses, where N is calibration bits 15:0. The current-tick value never exceeds N.
- R4: A calibration write clears the tick counter and restarts the sixteen-second correction sequence. The next boundary follows N+1 pulses later.
- R5: A set-time value reads back at once at address 1. It reaches the current time only at the next boundary. With no load pending, each boundary adds one to the time.
- R6: When calibration bit 20 is set and bits 19:16 hold F, the first F seconds of every sixteen, counted from the calibration write, last N+2 pulses. The other seconds last N+1 pulses.
- R7: Status bit 0 is set at every boundary. Status bit 1 is set at a boundary whose new time equals the alarm value. A 1 written to a status bit clears it and a 0 leaves it unchanged. Both bits latch whatever their enable state.
- R8: A 1 written at address 10 enables that source, and a 1 written at address 11 disables it. The enable state reads at address 9, with bit 0 for seconds and bit 1 for alarm.
- R9: `irq` is high exactly when some status bit is set and its source is enabled.
- R10: A read strobe places the selected register on `bus_rdata` after the same clock edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The assertions assume the following about the inputs:
- `osc_en` is a single-cycle pulse.
- `bus_wr` and `bus_rd` are never high together.
- Only a calibration write changes the programmed count.

The bench keeps within these assumptions in three ways:
- It raises each strobe for exactly one clock, from the falling edge.
- It sends oscillator pulses only while the bus is idle.
- It reprograms calibration before every timing test, so the tick counter and the correction sequence start from a known point.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic { TK_COUNT, TK_PAD } tick_state_t;
    typedef enum logic { TM_RUN, TM_ARMED } time_state_t;

    localparam logic [4:0] A_SET_WR = 5'd0;
    localparam logic [4:0] A_SET_RD = 5'd1;
    localparam logic [4:0] A_CAL_WR = 5'd2;
    localparam logic [4:0] A_CAL_RD = 5'd3;
    localparam logic [4:0] A_CUR    = 5'd4;
    localparam logic [4:0] A_TICK   = 5'd5;
    localparam logic [4:0] A_ALARM  = 5'd6;
    localparam logic [4:0] A_STAT   = 5'd8;
    localparam logic [4:0] A_MASK   = 5'd9;
    localparam logic [4:0] A_IEN    = 5'd10;
    localparam logic [4:0] A_IDIS   = 5'd11;
    localparam logic [4:0] A_CTRL   = 5'd16;

    localparam int NSRC    = 2;
    localparam int SRC_SEC = 0;
    localparam int SRC_ALM = 1;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              restart,
    input  logic [CNT_W-1:0]  cnt_max,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic              frac_on,
    output logic [CNT_W-1:0]  tick_cnt,
    output logic              sec_evt
);
    tick_state_t       st, nxt_st;
    logic [CNT_W-1:0]  nxt_cnt;
    logic [FRAC_W-1:0] seq, nxt_seq;
    logic              pad_need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= TK_COUNT;
            tick_cnt <= '0;
            seq      <= '0;
        end else begin
            st       <= nxt_st;
            tick_cnt <= nxt_cnt;
            seq      <= nxt_seq;
        end
    end

    always_comb begin
        nxt_st   = st;
        nxt_cnt  = tick_cnt;
        nxt_seq  = seq;
        sec_evt  = 1'b0;
        pad_need = frac_on && (seq < frac_val);
        if (restart) begin
            nxt_st  = TK_COUNT;
            nxt_cnt = '0;
            nxt_seq = '0;
        end else if (osc_en) begin
            unique case (st)
                TK_COUNT: begin
                    if (tick_cnt == cnt_max) begin
                        if (pad_need) begin
                            nxt_st = TK_PAD;
                        end else begin
                            sec_evt = 1'b1;
                            nxt_cnt = '0;
                            nxt_seq = seq + 1'b1;
                        end
                    end else begin
                        nxt_cnt = tick_cnt + 1'b1;
                    end
                end
                TK_PAD: begin
                    sec_evt = 1'b1;
                    nxt_cnt = '0;
                    nxt_seq = seq + 1'b1;
                    nxt_st  = TK_COUNT;
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_evt,
    input  logic              set_wr,
    input  logic [TIME_W-1:0] set_val,
    input  logic [TIME_W-1:0] alarm_val,
    output logic [TIME_W-1:0] secs,
    output logic [TIME_W-1:0] set_rb,
    output logic              alm_evt
);
    time_state_t       st, nxt_st;
    logic [TIME_W-1:0] nxt_secs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= TM_RUN;
            secs   <= '0;
            set_rb <= '0;
        end else begin
            st <= nxt_st;
            if (sec_evt) secs <= nxt_secs;
            if (set_wr)  set_rb <= set_val;
        end
    end

    always_comb begin
        nxt_st   = st;
        nxt_secs = secs + 1'b1;
        unique case (st)
            TM_RUN:   nxt_secs = secs + 1'b1;
            TM_ARMED: begin
                nxt_secs = set_rb;
                if (sec_evt) nxt_st = TM_RUN;
            end
        endcase
        if (set_wr) nxt_st = TM_ARMED;
        alm_evt = sec_evt && (nxt_secs == alarm_val);
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             clr_wr,
    input  logic             en_wr,
    input  logic             dis_wr,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] enabled,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status  <= '0;
            enabled <= '0;
        end else begin
            status <= (status & ~(clr_wr ? wbits : '0)) | evt;
            if (en_wr)       enabled <= enabled | wbits;
            else if (dis_wr) enabled <= enabled & ~wbits;
        end
    end

    assign irq = |(status & enabled);
endmodule

// File: rtl/secs_rtc_core.sv
module secs_rtc_core
    import rtc_pkg::*;
#(
    parameter int          TIME_W    = 32,
    parameter int          TICK_W    = 16,
    parameter int          FRAC_W    = 4,
    parameter int          ADDR_W    = 5,
    parameter logic [20:0] CAL_RESET = 21'h198233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CAL_W   = TICK_W + FRAC_W + 1;
    localparam int FEN_BIT = TICK_W + FRAC_W;
    localparam int BAT_BIT = 31;
    localparam int OSC_BIT = 24;

    logic [CAL_W-1:0]  cal_reg;
    logic [TIME_W-1:0] alarm_reg;
    logic              ctl_bat, ctl_osc;
    logic [TICK_W-1:0] tick_cnt;
    logic [TIME_W-1:0] secs, set_rb;
    logic              sec_evt, alm_evt;
    logic [NSRC-1:0]   irq_stat, irq_mask, evt;
    logic [31:0]       rd_mux;
    logic              wr_cal, wr_set;

    assign wr_cal = bus_wr && (bus_addr == ADDR_W'(A_CAL_WR));
    assign wr_set = bus_wr && (bus_addr == ADDR_W'(A_SET_WR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_reg   <= CAL_W'(CAL_RESET);
            alarm_reg <= '0;
            ctl_bat   <= 1'b0;
            ctl_osc   <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_CAL_WR)) cal_reg   <= bus_wdata[CAL_W-1:0];
            if (bus_addr == ADDR_W'(A_ALARM))  alarm_reg <= bus_wdata[TIME_W-1:0];
            if (bus_addr == ADDR_W'(A_CTRL)) begin
                ctl_bat <= bus_wdata[BAT_BIT];
                ctl_osc <= bus_wdata[OSC_BIT];
            end
        end
    end

    rtc_tick_gen #(.CNT_W(TICK_W), .FRAC_W(FRAC_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .restart  (wr_cal),
        .cnt_max  (cal_reg[TICK_W-1:0]),
        .frac_val (cal_reg[FEN_BIT-1:TICK_W]),
        .frac_on  (cal_reg[FEN_BIT]),
        .tick_cnt (tick_cnt),
        .sec_evt  (sec_evt)
    );

    rtc_time_keeper #(.TIME_W(TIME_W)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_evt   (sec_evt),
        .set_wr    (wr_set),
        .set_val   (bus_wdata[TIME_W-1:0]),
        .alarm_val (alarm_reg),
        .secs      (secs),
        .set_rb    (set_rb),
        .alm_evt   (alm_evt)
    );

    always_comb begin
        evt          = '0;
        evt[SRC_SEC] = sec_evt;
        evt[SRC_ALM] = alm_evt;
    end

    rtc_irq_ctrl #(.N_SRC(NSRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .clr_wr  (bus_wr && (bus_addr == ADDR_W'(A_STAT))),
        .en_wr   (bus_wr && (bus_addr == ADDR_W'(A_IEN))),
        .dis_wr  (bus_wr && (bus_addr == ADDR_W'(A_IDIS))),
        .wbits   (bus_wdata[NSRC-1:0]),
        .status  (irq_stat),
        .enabled (irq_mask),
        .irq     (irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            ADDR_W'(A_SET_WR), ADDR_W'(A_SET_RD): rd_mux = 32'(set_rb);
            ADDR_W'(A_CAL_WR), ADDR_W'(A_CAL_RD): rd_mux = 32'(cal_reg);
            ADDR_W'(A_CUR):   rd_mux = 32'(secs);
            ADDR_W'(A_TICK):  rd_mux = 32'(tick_cnt);
            ADDR_W'(A_ALARM): rd_mux = 32'(alarm_reg);
            ADDR_W'(A_STAT):  rd_mux = 32'(irq_stat);
            ADDR_W'(A_MASK), ADDR_W'(A_IEN), ADDR_W'(A_IDIS): rd_mux = 32'(irq_mask);
            ADDR_W'(A_CTRL): begin
                rd_mux[BAT_BIT] = ctl_bat;
                rd_mux[OSC_BIT] = ctl_osc;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int TICK_W = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              sec_evt,
    input logic [TIME_W-1:0] secs,
    input logic [TICK_W-1:0] tick_cnt,
    input logic [TICK_W-1:0] cnt_max,
    input logic [NSRC-1:0]   irq_stat,
    input logic [NSRC-1:0]   irq_mask,
    input logic              irq
);
    assert_tick_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= cnt_max);

    assert_cal_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_CAL_WR)) |=> (tick_cnt == '0));

    assert_set_deferred_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_SET_WR) && !sec_evt) |=> $stable(secs));

    assert_secs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(secs) |-> $past(sec_evt));

    assert_sec_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[SRC_SEC]) |-> $past(sec_evt));

    assert_enable_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_IEN) && bus_wdata[SRC_ALM]) |=> irq_mask[SRC_ALM]);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask != '0 && irq_stat != '0));
endmodule

bind secs_rtc_core rtc_checker #(.TIME_W(TIME_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sec_evt   (sec_evt),
    .secs      (secs),
    .tick_cnt  (tick_cnt),
    .cnt_max   (cal_reg[TICK_W-1:0]),
    .irq_stat  (irq_stat),
    .irq_mask  (irq_mask),
    .irq       (irq)
);

// File: tb/tb_secs_rtc_core.sv
`timescale 1ns/1ps
module tb_secs_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    secs_rtc_core dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    localparam logic [4:0] SETW = 5'd0, SETR = 5'd1, CALW = 5'd2, CALR = 5'd3, CUR = 5'd4,
                           TICK = 5'd5, ALM = 5'd6, STAT = 5'd8, MASK = 5'd9, IEN = 5'd10,
                           IDIS = 5'd11, CTRL = 5'd16;

    // {write?, addr, data}: write entries store, read entries compare
    localparam int NV = 18;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, ALM,  32'hDEADBEEF}, {1'b0, ALM,  32'hDEADBEEF},
        {1'b1, CTRL, 32'hFFFFFFFF}, {1'b0, CTRL, 32'h81000000},
        {1'b1, CTRL, 32'h01000000}, {1'b0, CTRL, 32'h01000000},
        {1'b1, CALW, 32'hFFFFFFFF}, {1'b0, CALR, 32'h001FFFFF},
        {1'b1, IEN,  32'h00000003}, {1'b0, MASK, 32'h00000003},
        {1'b1, IDIS, 32'h00000001}, {1'b0, MASK, 32'h00000002},
        {1'b1, IDIS, 32'h00000002}, {1'b0, MASK, 32'h00000000},
        {1'b1, SETW, 32'h00000055}, {1'b0, SETR, 32'h00000055},
        {1'b0, 5'd7, 32'h00000000}, {1'b1, ALM,  32'h00000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_en = 1'b1;
            @(negedge clk); osc_en = 1'b0;
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 calibration default", CALR, 32'h00198233);
        rd_chk("R1 enable state", MASK, 32'h0);
        rd_chk("R1 status", STAT, 32'h0);
        rd_chk("R1 current time", CUR, 32'h0);
        check("R1 irq low", {31'b0, irq}, 32'h0);

        // R2 R8 R10 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:0]);
            else rd_chk("R2 R8 R10 table", VEC[i][36:32], VEC[i][31:0]);
        end
        wr(CTRL, 32'h0);

        // R3 second period, N=3 -> 4 pulses
        wr(CALW, 32'd3);
        wr(STAT, 32'h3);
        pulse(3);
        rd_chk("R3 no boundary before N+1", STAT, 32'h0);
        rd_chk("R3 tick reaches N", TICK, 32'd3);
        pulse(1);
        rd_chk("R7 seconds bit set", STAT, 32'h1);
        check("R9 irq low while disabled", {31'b0, irq}, 32'h0);
        rd_chk("R5 pending load applied", CUR, 32'h55);
        wr(IEN, 32'h1);
        check("R9 irq high when enabled", {31'b0, irq}, 32'h1);
        wr(STAT, 32'h1);
        rd_chk("R7 write-one clears", STAT, 32'h0);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);

        // R5 deferred set-time
        wr(SETW, 32'd100);
        rd_chk("R5 not loaded yet", CUR, 32'h55);
        rd_chk("R5 readback", SETR, 32'd100);
        pulse(4);
        rd_chk("R5 loaded at boundary", CUR, 32'd100);
        pulse(4);
        rd_chk("R5 increment", CUR, 32'd101);

        // R4 calibration write restarts tick
        pulse(2);
        rd_chk("R4 tick mid-second", TICK, 32'd2);
        wr(CALW, 32'd3);
        rd_chk("R4 tick cleared", TICK, 32'd0);
        wr(STAT, 32'h3);
        pulse(3);
        rd_chk("R4 full period after write", STAT, 32'h0);
        pulse(1);
        rd_chk("R4 boundary after N+1", STAT, 32'h1);

        // R6 fractional correction F=2
        wr(CALW, 32'h00120003);
        wr(STAT, 32'h3);
        pulse(4);
        rd_chk("R6 first second padded", STAT, 32'h0);
        pulse(1);
        rd_chk("R6 first second end", STAT, 32'h1);
        wr(STAT, 32'h3);
        pulse(4);
        rd_chk("R6 second second padded", STAT, 32'h0);
        pulse(1);
        rd_chk("R6 second second end", STAT, 32'h1);
        wr(STAT, 32'h3);
        pulse(4);
        rd_chk("R6 third second unpadded", STAT, 32'h1);
        rd_chk("R6 time count", CUR, 32'd105);

        // R7 alarm
        wr(CALW, 32'd3);
        wr(IDIS, 32'h1);
        wr(ALM, 32'd107);
        wr(IEN, 32'h2);
        wr(STAT, 32'h3);
        pulse(4);
        rd_chk("R7 no alarm at 106", STAT, 32'h1);
        check("R9 irq low, alarm not hit", {31'b0, irq}, 32'h0);
        pulse(4);
        rd_chk("R7 alarm at 107", STAT, 32'h3);
        check("R9 irq on alarm", {31'b0, irq}, 32'h1);
        wr(STAT, 32'h2);
        rd_chk("R7 zero bit left alone", STAT, 32'h1);
        check("R9 irq drops", {31'b0, irq}, 32'h0);
        pulse(4);
        rd_chk("R7 alarm not repeated", STAT, 32'h1);

        wr(SETW, 32'd200);
        wr(ALM, 32'd200);
        wr(IDIS, 32'h2);
        wr(STAT, 32'h3);
        pulse(4);
        rd_chk("R5 loaded 200", CUR, 32'd200);
        rd_chk("R7 alarm latches while disabled", STAT, 32'h3);
        check("R9 irq masked", {31'b0, irq}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule